// File: doc/BRIEF.md
# ADC Conversion Trigger and Result Holding Register

This block is the digital control side of a 10-bit analog-to-digital converter. It sits between the converter core and an 8-bit register bus. A 4-bit select field chooses which event starts a conversion, and the block sends one start pulse at a time to the converter. It never starts a new conversion while one is still running.

When the converter returns a done pulse with its 10-bit value, the block keeps that value. It presents the value as a high byte and a low byte. The value can be aligned to the low end of the pair, or to the top of the pair, so that the high byte alone gives an 8-bit result.

A read of the low byte locks the pair. The lock stays until the high byte is read. This means a two-byte read always returns two halves of the same conversion.

Top module: `adc_trig_result`

## Requirements
- R1: After reset, `res_lo` and `res_hi` are 0 and `conv_start` is 0.
- R2: When `left_adj` is 0, `res_lo` holds result bits 7:0, bits 1:0 of `res_hi` hold result bits 9:8, and bits 7:2 of `res_hi` are 0.
- R3: When `left_adj` is 1, `res_hi` holds result bits 9:2, bits 7:6 of `res_lo` hold result bits 1:0, and bits 5:0 of `res_lo` are 0. Changing `left_adj` changes only the presentation, not the stored value.
- R4: After a cycle with `rd_lo` high, a `conv_done` does not change either byte, and its value is discarded. This lasts up to and including the cycle in which `rd_hi` is high.
- R5: Once a cycle with `rd_hi` high has passed, the next `conv_done` stores its value, which appears on the outputs in the following cycle.
- R6: Select code 0 (free running): while `auto_en` is 1, a start is issued whenever the converter is idle. In steady state this is the cycle after each `conv_done`.
- R7: Select codes 1, 2, 3, 4, 7 and 8 watch `trig_in[code-1]`. A rising edge sets a pending flag. A start is issued in the first cycle after the edge in which the converter is idle. Issuing the start clears the flag.
- R8: Select codes 5 and 6 watch `trig_in[4]` and `trig_in[5]` with no flag. A start is issued in any cycle where the input is high and the converter is idle. An event that arrives while a conversion is running is lost.
- R9: Select codes 9 to 15 never issue a start.
- R10: While `auto_en` is 0, no start is issued and any pending flag is cleared.
- R11: No start is issued from the cycle of a start until the cycle after the matching `conv_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_en | input | 1 | Auto-trigger enable |
| trig_sel | input | 4 | Trigger source select code |
| trig_in | input | 8 | Trigger source inputs; `trig_in[k-1]` belongs to code k |
| left_adj | input | 1 | 1 = result aligned to the top of the byte pair |
| conv_start | output | 1 | One-cycle conversion start pulse to the converter |
| conv_done | input | 1 | Conversion complete pulse from the converter |
| conv_data | input | 10 | Result value, valid with `conv_done` |
| rd_lo | input | 1 | Bus read strobe for the low byte |
| rd_hi | input | 1 | Bus read strobe for the high byte |
| res_lo | output | 8 | Low result byte |
| res_hi | output | 8 | High result byte |

## Verification
Free-running mode is run back to back with both alignments, which tells a stored value apart from its presentation. Flagged sources get edges both while idle and during a conversion. This separates an immediate start from a deferred start, and a long high level shows that only its edge counts. The flagless sources get short pulses during a conversion, to show the pulses are lost, and a steady high level, to show that conversions restart back to back. Reserved codes and a disabled trigger are driven with toggling inputs. A low-byte read followed by several done pulses, then a high-byte read, separates a frozen pair from a live one.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int RES_W  = 10;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 4;
  localparam int NUM_SRC = 8;

  typedef enum logic [1:0] {
    SRC_FREE  = 2'd0,
    SRC_FLAG  = 2'd1,
    SRC_EVENT = 2'd2,
    SRC_NONE  = 2'd3
  } src_kind_e;
endpackage

// File: rtl/adc_src_decode.sv
module adc_src_decode
  import adc_trig_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int NS = NUM_SRC,
  parameter logic [NS-1:0] EVENT_MASK = 8'b0011_0000
) (
  input  logic [SW-1:0] sel,
  input  logic [NS-1:0] src,
  input  logic [NS-1:0] src_prev,
  output src_kind_e     kind,
  output logic          lvl,
  output logic          rise
);
  logic [NS-1:0] hit;

  for (genvar g = 0; g < NS; g++) begin : g_hit
    assign hit[g] = (sel == SW'(g + 1));
  end

  always_comb begin
    lvl  = |(hit & src);
    rise = |(hit & src & ~src_prev);
    if (sel == '0)                kind = SRC_FREE;
    else if (|(hit & EVENT_MASK)) kind = SRC_EVENT;
    else if (|hit)                kind = SRC_FLAG;
    else                          kind = SRC_NONE;
  end
endmodule

// File: rtl/adc_start_ctl.sv
module adc_start_ctl
  import adc_trig_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      auto_en,
  input  src_kind_e kind,
  input  logic      lvl,
  input  logic      rise,
  input  logic      conv_done,
  output logic      conv_start
);
  logic busy_q, busy_d;
  logic flag_q, flag_d;
  logic req;

  always_comb begin
    unique case (kind)
      SRC_FREE:  req = 1'b1;
      SRC_FLAG:  req = flag_q;
      SRC_EVENT: req = lvl;
      default:   req = 1'b0;
    endcase
    conv_start = auto_en & ~busy_q & req;
    if (!auto_en) flag_d = 1'b0;
    else          flag_d = (flag_q & ~conv_start) | ((kind == SRC_FLAG) & rise);
    if (conv_start)     busy_d = 1'b1;
    else if (conv_done) busy_d = 1'b0;
    else                busy_d = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      flag_q <= flag_d;
    end
  end

  // R11: a start is followed by a cycle without a start
  a_r11_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R7: an edge seen while idle and not starting leads to a start next cycle
  a_r7_edge_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && kind == SRC_FLAG && rise && !busy_q && !conv_start)
      |=> (conv_start || !auto_en || kind != SRC_FLAG));
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold
  import adc_trig_pkg::*;
#(
  parameter int RW = RES_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          left_adj,
  input  logic          rd_lo,
  input  logic          rd_hi,
  input  logic          conv_done,
  input  logic [RW-1:0] conv_data,
  output logic [BW-1:0] res_lo,
  output logic [BW-1:0] res_hi
);
  localparam int PAD = 2 * BW - RW;

  logic          lock_q, lock_d;
  logic [RW-1:0] res_q, res_d;
  logic          cap_en;
  logic [2*BW-1:0] word;

  always_comb begin
    cap_en = conv_done & ~lock_q;
    res_d  = cap_en ? conv_data : res_q;
    if (rd_hi)      lock_d = 1'b0;
    else if (rd_lo) lock_d = 1'b1;
    else            lock_d = lock_q;
    if (left_adj) word = {res_q, {PAD{1'b0}}};
    else          word = {{PAD{1'b0}}, res_q};
  end

  assign res_hi = word[2*BW-1:BW];
  assign res_lo = word[BW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      res_q  <= '0;
    end else begin
      lock_q <= lock_d;
      if (cap_en) res_q <= res_d;
    end
  end

  // R4: while locked the held value does not move
  a_r4_frozen_pair: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(res_q));

  // R5: an unlocked completion is visible in the next cycle
  a_r5_capture_open: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && conv_done) |=> (res_q == $past(conv_data)));
endmodule

// File: rtl/adc_trig_result.sv
module adc_trig_result
  import adc_trig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_en,
  input  logic [SEL_W-1:0]  trig_sel,
  input  logic [NUM_SRC-1:0] trig_in,
  input  logic              left_adj,
  output logic              conv_start,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  input  logic              rd_lo,
  input  logic              rd_hi,
  output logic [BYTE_W-1:0] res_lo,
  output logic [BYTE_W-1:0] res_hi
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  logic [NUM_SRC-1:0]     src_prev_q;
  src_kind_e              kind;
  logic                   lvl, rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) src_prev_q <= '0;
    else            src_prev_q <= trig_in;
  end

  adc_src_decode #(.SW(SEL_W), .NS(NUM_SRC)) u_decode (
    .sel      (trig_sel),
    .src      (trig_in),
    .src_prev (src_prev_q),
    .kind     (kind),
    .lvl      (lvl),
    .rise     (rise)
  );

  adc_start_ctl u_start (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .auto_en    (auto_en),
    .kind       (kind),
    .lvl        (lvl),
    .rise       (rise),
    .conv_done  (conv_done),
    .conv_start (conv_start)
  );

  adc_result_hold #(.RW(RES_W), .BW(BYTE_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .left_adj  (left_adj),
    .rd_lo     (rd_lo),
    .rd_hi     (rd_hi),
    .conv_done (conv_done),
    .conv_data (conv_data),
    .res_lo    (res_lo),
    .res_hi    (res_hi)
  );

  // R9: reserved codes never start a conversion
  a_r9_reserved_silent: assert property (@(posedge clk) disable iff (!rst_int_n)
    (trig_sel > SEL_W'(NUM_SRC)) |-> !conv_start);

  // R10: disabled auto-trigger never starts a conversion
  a_r10_disabled_silent: assert property (@(posedge clk) disable iff (!rst_int_n)
    !auto_en |-> !conv_start);

  // R6: free running restarts one cycle after a completion
  a_r6_free_restart: assert property (@(posedge clk) disable iff (!rst_int_n)
    (conv_done && auto_en && trig_sel == '0)
      |=> (conv_start || !auto_en || trig_sel != '0));

  // R2: right alignment keeps the top of the high byte clear
  a_r2_right_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    !left_adj |-> (res_hi[BYTE_W-1:2] == '0));

  // R3: left alignment keeps the bottom of the low byte clear
  a_r3_left_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    left_adj |-> (res_lo[5:0] == '0));
endmodule

// File: tb/adc_trig_result_test.sv
module adc_trig_result_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       auto_en;
  logic [3:0] trig_sel;
  logic [7:0] trig_in;
  logic       left_adj;
  logic       conv_start;
  logic       conv_done;
  logic [9:0] conv_data;
  logic       rd_lo, rd_hi;
  logic [7:0] res_lo, res_hi;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_trig_result uut (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .trig_sel(trig_sel),
    .trig_in(trig_in), .left_adj(left_adj), .conv_start(conv_start),
    .conv_done(conv_done), .conv_data(conv_data), .rd_lo(rd_lo),
    .rd_hi(rd_hi), .res_lo(res_lo), .res_hi(res_hi)
  );

  // reference state
  bit       m_busy, m_flag, m_lock;
  bit [9:0] m_res;
  bit [7:0] m_prev;
  int       conv_cnt = 0;
  bit [9:0] next_val = 10'h2A5;
  bit [9:0] last_done_val;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string start_tag(input bit busy);
    if (busy) return "R11";
    if (!auto_en) return "R10";
    if (trig_sel == 0) return "R6";
    if (trig_sel == 5 || trig_sel == 6) return "R8";
    if (trig_sel <= 8) return "R7";
    return "R9";
  endfunction

  // converter model: done pulse four cycles after a start
  always @(posedge clk) begin
    #1;
    conv_done = 1'b0;
    if (conv_cnt > 0) begin
      conv_cnt--;
      if (conv_cnt == 0) begin
        conv_done = 1'b1;
        conv_data = next_val;
        last_done_val = next_val;
        next_val = next_val * 10'd37 + 10'd11;
      end
    end
  end

  // cycle-by-cycle reference compared on every falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_flag = 0; m_lock = 0; m_res = '0; m_prev = '0;
    end else begin
      bit req, exp_start, rise;
      bit [15:0] w;
      int s;
      s = trig_sel;
      if (s == 0) req = 1;
      else if (s == 5 || s == 6) req = trig_in[s-1];
      else if (s <= 8) req = m_flag;
      else req = 0;
      exp_start = auto_en && !m_busy && req;
      check(start_tag(m_busy), conv_start, exp_start);
      w = left_adj ? {m_res, 6'b0} : {6'b0, m_res};
      check(m_lock ? "R4" : (left_adj ? "R3" : "R2"), res_hi, w[15:8]);
      check(m_lock ? "R4" : (left_adj ? "R3" : "R2"), res_lo, w[7:0]);
      if (conv_start) conv_cnt = 4;
      rise = (s >= 1 && s <= 8 && s != 5 && s != 6) && trig_in[s-1] && !m_prev[s-1];
      m_flag = auto_en ? ((m_flag && !exp_start) || rise) : 0;
      if (conv_done && !m_lock) m_res = conv_data;
      if (exp_start) m_busy = 1; else if (conv_done) m_busy = 0;
      if (rd_hi) m_lock = 0; else if (rd_lo) m_lock = 1;
      m_prev = trig_in;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_in(input int idx, input int len);
    trig_in[idx] = 1'b1;
    step(len);
    trig_in[idx] = 1'b0;
  endtask

  task automatic wait_idle();
    while (conv_cnt != 0) step(1);
    step(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit [7:0] snap_lo, snap_hi;
    rst_n = 0; auto_en = 0; trig_sel = 0; trig_in = '0; left_adj = 0;
    conv_done = 0; conv_data = '0; rd_lo = 0; rd_hi = 0;
    step(3);
    // R1 reset state
    check("R1", res_lo, 0);
    check("R1", res_hi, 0);
    check("R1", conv_start, 0);
    rst_n = 1;
    step(4);

    // R6 free running, right then left alignment (R2, R3)
    auto_en = 1; trig_sel = 0;
    step(30);
    left_adj = 1;
    step(20);
    left_adj = 0;

    // R4 lock, then R5 release
    rd_lo = 1; step(1); rd_lo = 0;
    snap_lo = res_lo; snap_hi = res_hi;
    step(25);
    check("R4", res_lo, snap_lo);
    check("R4", res_hi, snap_hi);
    rd_hi = 1; step(1); rd_hi = 0;
    while (!conv_done) step(1);
    step(1);
    check("R5", res_lo, last_done_val[7:0]);
    check("R5", res_hi, {6'b0, last_done_val[9:8]});

    // R10 disable
    auto_en = 0;
    wait_idle();
    step(10);
    check("R10", conv_cnt, 0);

    // R7 flagged sources: idle edge, edge while busy, long level
    auto_en = 1; trig_sel = 1;
    pulse_in(0, 1); step(2);
    pulse_in(0, 1);
    wait_idle();
    trig_sel = 3;
    pulse_in(2, 12);
    step(3);
    pulse_in(2, 2);
    wait_idle();
    trig_sel = 8;
    pulse_in(7, 1); step(1); pulse_in(7, 1);
    wait_idle();

    // R8 flagless events: pulses during a conversion are lost
    trig_sel = 5;
    pulse_in(4, 1); step(1);
    pulse_in(4, 1); step(1);
    pulse_in(4, 1);
    wait_idle();
    trig_sel = 6;
    pulse_in(5, 20);
    wait_idle();

    // R9 reserved codes with toggling inputs
    for (int c = 9; c < 16; c++) begin
      trig_sel = 4'(c);
      trig_in = 8'hFF; step(2);
      trig_in = 8'h00; step(2);
    end
    check("R9", conv_cnt, 0);

    // R11 flagged edges stacked inside one conversion yield one later start
    trig_sel = 2;
    pulse_in(1, 1); step(1);
    pulse_in(1, 1); step(1);
    wait_idle();
    auto_en = 0;
    step(4);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule